// File: doc/BRIEF.md
# Latched Seven-Segment Decoder with Zero Blanking

This block turns a 4-bit binary code into the seven active-low segment drives of a common-anode display. A storage register sits in front of the decoder. While the active-low load strobe is low, the register takes a new code on every clock edge. While the strobe is high, the register keeps its value, so the display stays steady even if the code bus is being shared with other digits.

Zero suppression is built for chains of digits. Each digit has an active-low ripple-blank input. When that input is asserted and the stored code is zero, the digit goes dark and pulls its own ripple-blank output low. Wiring that output to the ripple-blank input of the next less significant digit removes leading zeros, and the same wiring run the other way removes trailing zeros.

A separate active-low force-off input darkens every segment, whatever is stored and whatever the ripple input says. A pulse-width signal on this input can be used to dim the display. The stored code and the load strobe keep working while the force is applied. Storage is clocked. The ripple-blank input and the force input act on the outputs without going through a register.

Top module: `seg_decoder_top`

## Requirements
- R1: While le_n is low at a rising clock edge (and rst_n is high), the stored code takes the value of code_i, and the segments show it after that edge.
- R2: While le_n is high at a rising clock edge, the stored code and the segments do not change, whatever code_i does.
- R3: Segment bits are active low: seg_n[0]=a, [1]=b, [2]=c, [3]=d, [4]=e, [5]=f, [6]=g. A synchronous reset (rst_n low at an edge) stores code 15. With the blanking inputs released, this gives seg_n=7'h7F and rbo_n=1.
- R4: Codes 0–9 light these segments: 0=abcdef, 1=bc, 2=abdeg, 3=abcdg, 4=bcfg, 5=acdfg, 6=acdefg, 7=abc, 8=abcdefg, 9=abcdfg.
- R5: Codes 10–15 light these segments: 10 (dash)=g, 11 (E)=adefg, 12 (H)=bcefg, 13 (L)=def, 14 (P)=abefg, 15=none.
- R6: When the stored code is 0 and rbi_n is low, every segment is off and rbo_n is low.
- R7: In every other case rbo_n is high. A stored 0 with rbi_n high shows the digit 0. A nonzero code with rbi_n low shows its normal pattern.
- R8: When force_n is low, seg_n is 7'h7F for every stored code and every rbi_n. rbo_n still follows R6/R7.
- R9: The register still loads while force_n is low. After force_n is released, the code loaded during the force is shown.
- R10: Changes on rbi_n and force_n reach seg_n and rbo_n without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| le_n | input | 1 | Load strobe, active low: register loads while low |
| code_i | input | 4 | Binary code to display |
| rbi_n | input | 1 | Ripple-blank input, active low |
| force_n | input | 1 | Force all segments off, active low |
| seg_n | output | 7 | Segment drives a..g, active low |
| rbo_n | output | 1 | Ripple-blank output, active low |

## Verification
All sixteen codes are loaded one after another and compared against a fixed glyph table. This separates swapped segment bits, as well as the easily confused glyphs such as 6 against the variant without a top bar, or 9 against the variant without a bottom bar. Hold is tested by changing code_i while the strobe is high, which tells a storage register apart from a plain wire. The ripple input is applied to zero and to nonzero codes, with force on and off. This shows that blanking depends on the stored zero, that rbo_n depends on the ripple condition alone, and that force only masks the segments and does not stop the register from loading.

// File: rtl/seg_pkg.sv
package seg_pkg;
    localparam int CODE_W = 4;
    localparam int SEG_W  = 7;
    localparam int NUM_CODES = 1 << CODE_W;

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [SEG_W-1:0]  seg_t;

    // lit segment set, bit0 = a ... bit6 = g, 1 = segment on
    function automatic seg_t glyph_lit(input code_t c);
        seg_t s;
        case (c)
            4'd0:    s = 7'h3F;
            4'd1:    s = 7'h06;
            4'd2:    s = 7'h5B;
            4'd3:    s = 7'h4F;
            4'd4:    s = 7'h66;
            4'd5:    s = 7'h6D;
            4'd6:    s = 7'h7D;
            4'd7:    s = 7'h07;
            4'd8:    s = 7'h7F;
            4'd9:    s = 7'h6F;
            4'd10:   s = 7'h40; // dash
            4'd11:   s = 7'h79; // E
            4'd12:   s = 7'h76; // H
            4'd13:   s = 7'h38; // L
            4'd14:   s = 7'h73; // P
            default: s = 7'h00; // blank
        endcase
        return s;
    endfunction
endpackage

// File: rtl/seg_code_latch.sv
module seg_code_latch
    import seg_pkg::*;
#(
    parameter code_t RST_CODE = code_t'(NUM_CODES - 1)
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  le_n,
    input  code_t code_i,
    output code_t code_o
);
    typedef struct packed {
        code_t code;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!le_n) begin
            st_d.code = code_i;
        end
        if (!rst_n) begin
            st_d.code = RST_CODE;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign code_o = st_q.code;

    // R1
    latch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !le_n |=> code_o == $past(code_i));

    // R2
    latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        le_n |=> $stable(code_o));
endmodule

// File: rtl/seg_glyph_rom.sv
module seg_glyph_rom
    import seg_pkg::*;
(
    input  code_t code_i,
    output seg_t  lit_o,
    output logic  is_zero_o
);
    always_comb begin
        lit_o     = glyph_lit(code_i);
        is_zero_o = (code_i == '0);
    end
endmodule

// File: rtl/seg_blank_ctrl.sv
module seg_blank_ctrl
    import seg_pkg::*;
(
    input  seg_t lit_i,
    input  logic is_zero_i,
    input  logic rbi_n,
    input  logic force_n,
    output seg_t seg_n,
    output logic rbo_n
);
    logic ripple_blank;

    always_comb begin
        ripple_blank = is_zero_i && !rbi_n;
        rbo_n        = !ripple_blank;
        if (ripple_blank || !force_n) begin
            seg_n = '1;
        end else begin
            seg_n = ~lit_i;
        end
    end
endmodule

// File: rtl/seg_decoder_top.sv
module seg_decoder_top
    import seg_pkg::*;
#(
    parameter code_t RST_CODE = code_t'(NUM_CODES - 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                le_n,
    input  logic [CODE_W-1:0]   code_i,
    input  logic                rbi_n,
    input  logic                force_n,
    output logic [SEG_W-1:0]    seg_n,
    output logic                rbo_n
);
    code_t stored_code;
    seg_t  lit;
    logic  is_zero;

    seg_code_latch #(.RST_CODE(RST_CODE)) u_latch (
        .clk    (clk),
        .rst_n  (rst_n),
        .le_n   (le_n),
        .code_i (code_i),
        .code_o (stored_code)
    );

    seg_glyph_rom u_rom (
        .code_i    (stored_code),
        .lit_o     (lit),
        .is_zero_o (is_zero)
    );

    seg_blank_ctrl u_blank (
        .lit_i     (lit),
        .is_zero_i (is_zero),
        .rbi_n     (rbi_n),
        .force_n   (force_n),
        .seg_n     (seg_n),
        .rbo_n     (rbo_n)
    );

    // R8
    force_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !force_n |-> seg_n == '1);

    // R6
    ripple_dark_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rbo_n |-> seg_n == '1);

    // R7
    ripple_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rbi_n |-> rbo_n);
endmodule

// File: tb/test_seg_decoder_top.sv
`timescale 1ns/1ps
module test_seg_decoder_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       le_n = 1'b1;
    logic [3:0] code_i = 4'd0;
    logic       rbi_n = 1'b1;
    logic       force_n = 1'b1;
    logic [6:0] seg_n;
    logic       rbo_n;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    seg_decoder_top i_seg_decoder_top (
        .clk(clk), .rst_n(rst_n), .le_n(le_n), .code_i(code_i),
        .rbi_n(rbi_n), .force_n(force_n), .seg_n(seg_n), .rbo_n(rbo_n)
    );

    // expected active-low drive, written from the segment lists of R4/R5
    function automatic logic [6:0] exp_seg(input int c);
        logic [6:0] lit;
        case (c)
            0: lit = 7'b0111111;  1: lit = 7'b0000110;
            2: lit = 7'b1011011;  3: lit = 7'b1001111;
            4: lit = 7'b1100110;  5: lit = 7'b1101101;
            6: lit = 7'b1111101;  7: lit = 7'b0000111;
            8: lit = 7'b1111111;  9: lit = 7'b1101111;
            10: lit = 7'b1000000; 11: lit = 7'b1111001;
            12: lit = 7'b1110110; 13: lit = 7'b0111000;
            14: lit = 7'b1110011; default: lit = 7'b0000000;
        endcase
        return ~lit;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic load(input logic [3:0] c);
        @(negedge clk);
        code_i = c;
        le_n = 1'b0;
        @(negedge clk);
        le_n = 1'b1;
    endtask

    task automatic t_reset;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R3 reset seg", {1'b0, seg_n}, 8'h7F);
        check("R3 reset rbo", {7'b0, rbo_n}, 8'h01);
    endtask

    task automatic t_all_codes;
        for (int c = 0; c < 16; c++) begin
            load(4'(c));
            if (c < 10) check($sformatf("R4 R1 code %0d", c), {1'b0, seg_n}, {1'b0, exp_seg(c)});
            else        check($sformatf("R5 R1 code %0d", c), {1'b0, seg_n}, {1'b0, exp_seg(c)});
            check("R7 rbo high", {7'b0, rbo_n}, 8'h01);
        end
    endtask

    task automatic t_hold;
        load(4'd3);
        @(negedge clk);
        code_i = 4'd8;
        repeat (3) @(negedge clk);
        check("R2 hold", {1'b0, seg_n}, {1'b0, exp_seg(3)});
        code_i = 4'd1;
        @(negedge clk);
        check("R2 hold again", {1'b0, seg_n}, {1'b0, exp_seg(3)});
    endtask

    task automatic t_ripple;
        load(4'd0);
        check("R7 zero shown", {1'b0, seg_n}, {1'b0, exp_seg(0)});
        rbi_n = 1'b0;
        #0.5;
        check("R6 R10 zero blanked", {1'b0, seg_n}, 8'h7F);
        check("R6 rbo low", {7'b0, rbo_n}, 8'h00);
        load(4'd7);
        check("R7 nonzero with rbi", {1'b0, seg_n}, {1'b0, exp_seg(7)});
        check("R7 rbo high nonzero", {7'b0, rbo_n}, 8'h01);
        rbi_n = 1'b1;
    endtask

    task automatic t_force;
        load(4'd5);
        force_n = 1'b0;
        #0.5;
        check("R8 R10 force dark", {1'b0, seg_n}, 8'h7F);
        load(4'd0);
        rbi_n = 1'b0;
        #0.5;
        check("R8 rbo follows ripple", {7'b0, rbo_n}, 8'h00);
        rbi_n = 1'b1;
        #0.5;
        check("R8 force dark zero", {1'b0, seg_n}, 8'h7F);
        check("R8 rbo high", {7'b0, rbo_n}, 8'h01);
        load(4'd12);
        force_n = 1'b1;
        #0.5;
        check("R9 load during force", {1'b0, seg_n}, {1'b0, exp_seg(12)});
    endtask

    initial begin
        t_reset();
        t_all_codes();
        t_hold();
        t_ripple();
        t_force();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog actual=running expected=done");
            end
        join_any
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule